// File: doc/BRIEF.md
# Dual-Core Hardware Semaphore Bank

This block holds a bank of hardware semaphores that two processor cores use to guard shared resources. Each semaphore stores a lock flag, the ID of the core that owns it and a process ID chosen by that core. A core can claim a semaphore in two ways. It can write a lock request and then read the entry back to confirm that it won. It can also issue a single read of the semaphore's claim address, which takes the semaphore if it is free and reports the owner either way. Only the exact owner can release a semaphore, and the request must come from the owning bus master.

Every successful release raises a per-semaphore event in both cores' status registers. Each core has its own enable mask and its own write-one-to-clear register, and it gets an interrupt line that combines its status and its enable mask. Access is through a single-cycle request port: valid, write, word address, write data and a master-ID sideband. Reads return their data on a registered response one cycle later.

Top module: `hw_sem_bank`

## Requirements
- R1: After reset every semaphore reads 0, both status and enable registers read 0 and irq_o is 0.
- R2: A semaphore word holds LOCK at bit 31, COREID at bits 11:8 and PROCID at bits 7:0. A write to semaphore address i (0..31) with LOCK=1 and COREID equal to req_master_i takes a free semaphore, and a later read returns LOCK=1 with the written COREID and PROCID.
- R3: A lock write to a semaphore that is already locked leaves it unchanged.
- R4: A lock or unlock write whose COREID differs from req_master_i has no effect.
- R5: A read of claim address 32+i for a free semaphore locks it with COREID=req_master_i and PROCID=0, and returns that word.
- R6: A claim read of a locked semaphore leaves it unchanged and returns the current owner's word.
- R7: A write with LOCK=0 whose COREID and PROCID match the stored owner, sent by the owning master, frees the semaphore, and it then reads 0.
- R8: An unlock write that does not match the owner is ignored. The semaphore stays locked and no status bit is set.
- R9: A successful unlock of semaphore i sets bit i in both status registers (core 0 at address 66, core 1 at address 70).
- R10: irq_o[c] is 1 exactly when core c's status register and its enable register (core 0 at address 64, core 1 at address 68) share a set bit.
- R11: Writing 1 to a bit of a core's clear register (core 0 at address 65, core 1 at address 69) clears that status bit. Writing 0 has no effect. When a clear and a new unlock event hit the same bit in the same cycle, the bit stays set.
- R12: Reading a plain semaphore address has no side effect. A write or read at an unmapped address (96 and above, 67, 71) changes nothing, and such a read returns 0.
- R13: rsp_valid_o is 1 in the cycle after each accepted read and 0 after a write or an idle cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Access request this cycle |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 7 | Word address |
| req_wdata_i | input | 32 | Write data |
| req_master_i | input | 4 | ID of the requesting bus master |
| rsp_valid_o | output | 1 | Read data valid |
| rsp_rdata_o | output | 32 | Read data |
| irq_o | output | 2 | Per-core interrupt |

## Verification
On every cycle the assertions check the following. A freed semaphore always carries zero IDs. A lock flag drops only on a matching unlock event. A lock appears only after an access. A status bit rises only from an unlock event, and every event reaches both cores' status registers. Unmapped accesses leave the state untouched, and the response follows the read timing. Other properties depend on a stimulus sequence and only the bench scenarios can show them: that a winner's read-back shows its own IDs, that a claim read reports the current owner, that mismatched IDs are ignored, and that the enable masks and clears shape each interrupt line.

// File: rtl/hsem_pkg.sv
`timescale 1ns/1ps
package hsem_pkg;
  typedef enum logic [1:0] {RG_SEM = 2'd0, RG_CLAIM = 2'd1, RG_CORE = 2'd2, RG_NONE = 2'd3} region_e;
  localparam int LOCK_BIT = 31;
  localparam int CID_LSB  = 8;
  // core register offsets inside RG_CORE: core c at base 4*c
  localparam int OFS_EN   = 0;
  localparam int OFS_CLR  = 1;
  localparam int OFS_STS  = 2;
  localparam int N_CORE   = 2;
endpackage

// File: rtl/hsem_cell.sv
`timescale 1ns/1ps
module hsem_cell #(
  parameter int CID_W = 4,
  parameter int PID_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic             claim_en_i,
  input  logic             wlock_i,
  input  logic [CID_W-1:0] wcid_i,
  input  logic [PID_W-1:0] wpid_i,
  input  logic [CID_W-1:0] master_i,
  output logic             lock_o,
  output logic [CID_W-1:0] cid_o,
  output logic [PID_W-1:0] pid_o,
  output logic             free_o
);
  logic             lock_q;
  logic [CID_W-1:0] cid_q;
  logic [PID_W-1:0] pid_q;
  logic             cid_ok, take_w, take_r;

  assign cid_ok = (wcid_i == master_i);
  assign take_w = wr_en_i & wlock_i & cid_ok & ~lock_q;
  assign take_r = claim_en_i & ~lock_q;
  assign free_o = wr_en_i & ~wlock_i & lock_q & cid_ok & (wcid_i == cid_q) & (wpid_i == pid_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lock_q <= 1'b0;
      cid_q  <= '0;
      pid_q  <= '0;
    end else if (take_w) begin
      lock_q <= 1'b1;
      cid_q  <= wcid_i;
      pid_q  <= wpid_i;
    end else if (take_r) begin
      lock_q <= 1'b1;
      cid_q  <= master_i;
      pid_q  <= '0;
    end else if (free_o) begin
      lock_q <= 1'b0;
      cid_q  <= '0;
      pid_q  <= '0;
    end
  end

  assign lock_o = lock_q;
  assign cid_o  = cid_q;
  assign pid_o  = pid_q;
endmodule

// File: rtl/hsem_irq.sv
`timescale 1ns/1ps
module hsem_irq #(
  parameter int N_SEM = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_we_i,
  input  logic             clr_we_i,
  input  logic [N_SEM-1:0] wdata_i,
  input  logic [N_SEM-1:0] set_i,
  output logic [N_SEM-1:0] en_o,
  output logic [N_SEM-1:0] sts_o,
  output logic             irq_o
);
  logic [N_SEM-1:0] en_q, sts_q, clr_mask;

  assign clr_mask = clr_we_i ? wdata_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= '0;
      sts_q <= '0;
    end else begin
      if (en_we_i) en_q <= wdata_i;
      sts_q <= (sts_q & ~clr_mask) | set_i;  // new event wins over clear
    end
  end

  assign en_o  = en_q;
  assign sts_o = sts_q;
  assign irq_o = |(sts_q & en_q);
endmodule

// File: rtl/hw_sem_bank.sv
`timescale 1ns/1ps
module hw_sem_bank #(
  parameter int N_SEM = 32,
  parameter int CID_W = 4,
  parameter int PID_W = 8,
  localparam int IDX_W = $clog2(N_SEM),
  localparam int AW    = IDX_W + 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  input  logic             req_write_i,
  input  logic [AW-1:0]    req_addr_i,
  input  logic [31:0]      req_wdata_i,
  input  logic [CID_W-1:0] req_master_i,
  output logic             rsp_valid_o,
  output logic [31:0]      rsp_rdata_o,
  output logic [1:0]       irq_o
);
  import hsem_pkg::*;

  region_e          region;
  logic [IDX_W-1:0] idx;
  logic             acc_wr, acc_rd;
  logic             wlock;
  logic [CID_W-1:0] wcid;
  logic [PID_W-1:0] wpid;

  logic [N_SEM-1:0]             lock_vec, free_vec;
  logic [N_SEM-1:0][CID_W-1:0]  cid_arr;
  logic [N_SEM-1:0][PID_W-1:0]  pid_arr;
  logic [N_CORE-1:0][N_SEM-1:0] en_arr, sts_arr;

  assign region = region_e'(req_addr_i[AW-1 -: 2]);
  assign idx    = req_addr_i[IDX_W-1:0];
  assign acc_wr = req_valid_i & req_write_i;
  assign acc_rd = req_valid_i & ~req_write_i;
  assign wlock  = req_wdata_i[LOCK_BIT];
  assign wcid   = req_wdata_i[CID_LSB +: CID_W];
  assign wpid   = req_wdata_i[PID_W-1:0];

  logic unused_wdata;
  assign unused_wdata = ^{req_wdata_i[30:CID_LSB+CID_W]};

  function automatic logic [31:0] pack_word(logic l, logic [CID_W-1:0] c, logic [PID_W-1:0] p);
    logic [31:0] w;
    w = '0;
    w[LOCK_BIT] = l;
    w[CID_LSB +: CID_W] = c;
    w[PID_W-1:0] = p;
    return w;
  endfunction

  for (genvar g = 0; g < N_SEM; g++) begin : g_sem
    hsem_cell #(.CID_W(CID_W), .PID_W(PID_W)) u_cell (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .wr_en_i    (acc_wr && region == RG_SEM && idx == IDX_W'(g)),
      .claim_en_i (acc_rd && region == RG_CLAIM && idx == IDX_W'(g)),
      .wlock_i    (wlock),
      .wcid_i     (wcid),
      .wpid_i     (wpid),
      .master_i   (req_master_i),
      .lock_o     (lock_vec[g]),
      .cid_o      (cid_arr[g]),
      .pid_o      (pid_arr[g]),
      .free_o     (free_vec[g])
    );
  end

  for (genvar c = 0; c < N_CORE; c++) begin : g_core
    logic core_sel;
    assign core_sel = (region == RG_CORE) && (idx[IDX_W-1:2] == (IDX_W-2)'(c));
    hsem_irq #(.N_SEM(N_SEM)) u_irq (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .en_we_i  (acc_wr && core_sel && idx[1:0] == 2'(OFS_EN)),
      .clr_we_i (acc_wr && core_sel && idx[1:0] == 2'(OFS_CLR)),
      .wdata_i  (req_wdata_i[N_SEM-1:0]),
      .set_i    (free_vec),
      .en_o     (en_arr[c]),
      .sts_o    (sts_arr[c]),
      .irq_o    (irq_o[c])
    );
  end

  logic [31:0] rd_d;
  always_comb begin
    rd_d = '0;
    unique case (region)
      RG_SEM:   rd_d = pack_word(lock_vec[idx], cid_arr[idx], pid_arr[idx]);
      RG_CLAIM: rd_d = lock_vec[idx] ? pack_word(1'b1, cid_arr[idx], pid_arr[idx])
                                     : pack_word(1'b1, req_master_i, '0);
      RG_CORE: begin
        for (int c = 0; c < N_CORE; c++) begin
          if (idx[IDX_W-1:2] == (IDX_W-2)'(c)) begin
            if (idx[1:0] == 2'(OFS_EN))  rd_d = 32'(en_arr[c]);
            if (idx[1:0] == 2'(OFS_STS)) rd_d = 32'(sts_arr[c]);
          end
        end
      end
      default:  rd_d = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      rsp_rdata_o <= '0;
    end else begin
      rsp_valid_o <= acc_rd;
      if (acc_rd) rsp_rdata_o <= rd_d;
    end
  end
endmodule

// File: rtl/hsem_chk.sv
`timescale 1ns/1ps
module hsem_chk #(
  parameter int N_SEM = 32,
  parameter int CID_W = 4,
  parameter int PID_W = 8,
  parameter int AW    = 7
) (
  input logic                            clk_i,
  input logic                            rst_ni,
  input logic                            req_valid_i,
  input logic                            req_write_i,
  input logic [AW-1:0]                   req_addr_i,
  input logic                            rsp_valid_o,
  input logic [N_SEM-1:0]                lock_vec,
  input logic [N_SEM-1:0]                free_vec,
  input logic [N_SEM-1:0][CID_W-1:0]     cid_arr,
  input logic [N_SEM-1:0][PID_W-1:0]     pid_arr,
  input logic [1:0][N_SEM-1:0]           sts_arr
);
  logic unmapped;
  assign unmapped = req_valid_i && (req_addr_i[AW-1 -: 2] == 2'b11);

  for (genvar g = 0; g < N_SEM; g++) begin : g_free
    p_free_zero_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !lock_vec[g] |-> (cid_arr[g] == '0 && pid_arr[g] == '0));
  end

  p_lock_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((~lock_vec & $past(lock_vec) & ~$past(free_vec)) == '0));

  p_lock_needs_access_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> ((lock_vec & ~$past(lock_vec)) == '0));

  p_evt_sets_sts_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (free_vec != '0) |=> (((sts_arr[0] & $past(free_vec)) == $past(free_vec)) &&
                         ((sts_arr[1] & $past(free_vec)) == $past(free_vec))));

  p_sts_only_evt_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (((sts_arr[0] & ~$past(sts_arr[0]) & ~$past(free_vec)) == '0) &&
              ((sts_arr[1] & ~$past(sts_arr[1]) & ~$past(free_vec)) == '0)));

  p_unmapped_stable_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unmapped |=> ($stable(lock_vec) && $stable(sts_arr)));

  p_rsp_on_read_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !req_write_i) |=> rsp_valid_o);

  p_no_rsp_else_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_valid_i && !req_write_i) |=> !rsp_valid_o);
endmodule

bind hw_sem_bank hsem_chk #(.N_SEM(N_SEM), .CID_W(CID_W), .PID_W(PID_W), .AW(AW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .req_write_i (req_write_i),
  .req_addr_i  (req_addr_i),
  .rsp_valid_o (rsp_valid_o),
  .lock_vec    (lock_vec),
  .free_vec    (free_vec),
  .cid_arr     (cid_arr),
  .pid_arr     (pid_arr),
  .sts_arr     (sts_arr)
);

// File: tb/hw_sem_bank_tb_top.sv
`timescale 1ns/1ps
module hw_sem_bank_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [6:0]  req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic [3:0]  req_master = '0;
  logic        rsp_valid;
  logic [31:0] rsp_rdata;
  logic [1:0]  irq;

  int n_tests = 0, n_fail = 0;
  bit done = 1'b0;

  typedef struct { logic [31:0] data; string tag; } exp_t;
  exp_t exp_q[$];

  always #5 clk = ~clk;

  hw_sem_bank dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_write_i(req_write),
    .req_addr_i(req_addr), .req_wdata_i(req_wdata), .req_master_i(req_master),
    .rsp_valid_o(rsp_valid), .rsp_rdata_o(rsp_rdata), .irq_o(irq)
  );

  localparam logic [6:0] A_EN0 = 7'd64, A_CLR0 = 7'd65, A_STS0 = 7'd66;
  localparam logic [6:0] A_EN1 = 7'd68, A_STS1 = 7'd70;

  function automatic logic [31:0] w(logic l, logic [3:0] c, logic [7:0] p);
    return {l, 19'd0, c, p};
  endfunction

  task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] m, logic [6:0] a, logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d; req_master = m;
    @(negedge clk);
    req_valid = 1'b0;
    check(rsp_valid == 1'b0, "R13 no response to write", 32'(rsp_valid), 32'd0);
  endtask

  task automatic rd(logic [3:0] m, logic [6:0] a, logic [31:0] e, string tag);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a; req_master = m;
    exp_q.push_back('{data: e, tag: tag});
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  // monitor: responses are registered, visible at the negedge after the request cycle
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R13 unexpected response", rsp_rdata, 32'd0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        check(rsp_rdata == e.data, e.tag, rsp_rdata, e.data);
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  initial begin
    #200000;
    n_tests++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(irq == 2'b00, "R1 irq after reset", 32'(irq), 32'd0);
    rd(4'd1, 7'd0,  32'd0, "R1 sem0 reset");
    rd(4'd1, 7'd31, 32'd0, "R1 sem31 reset");
    rd(4'd1, A_STS0, 32'd0, "R1 sts0 reset");
    rd(4'd2, A_EN1,  32'd0, "R1 en1 reset");

    wr(4'd1, A_EN0, 32'h18);
    wr(4'd2, A_EN1, 32'h08);
    rd(4'd1, A_EN0, 32'h18, "R10 en0 readback");

    // R2 two-step lock
    wr(4'd1, 7'd3, w(1, 4'd1, 8'h5A));
    rd(4'd1, 7'd3, w(1, 4'd1, 8'h5A), "R2 two-step lock readback");
    // R3 lock on locked semaphore
    wr(4'd2, 7'd3, w(1, 4'd2, 8'h11));
    rd(4'd2, 7'd3, w(1, 4'd1, 8'h5A), "R3 locked sem unchanged");
    // R4 COREID not matching master
    wr(4'd2, 7'd4, w(1, 4'd1, 8'h22));
    rd(4'd2, 7'd4, 32'd0, "R4 mismatched lock ignored");
    // R5 claim read of free semaphore
    rd(4'd2, 7'd36, w(1, 4'd2, 8'h00), "R5 claim read returns new owner");
    rd(4'd1, 7'd4,  w(1, 4'd2, 8'h00), "R5 claim persisted");
    // R6 claim read of locked semaphore
    rd(4'd1, 7'd36, w(1, 4'd2, 8'h00), "R6 claim read of locked");
    rd(4'd1, 7'd4,  w(1, 4'd2, 8'h00), "R6 owner unchanged");

    // R8 non-matching unlocks
    wr(4'd1, 7'd3, w(0, 4'd1, 8'h5B));
    rd(4'd1, 7'd3, w(1, 4'd1, 8'h5A), "R8 wrong PROCID unlock ignored");
    wr(4'd2, 7'd3, w(0, 4'd1, 8'h5A));
    rd(4'd1, 7'd3, w(1, 4'd1, 8'h5A), "R4 unlock from wrong master ignored");
    rd(4'd1, A_STS0, 32'd0, "R8 no status after bad unlock");
    check(irq == 2'b00, "R8 no irq after bad unlock", 32'(irq), 32'd0);

    // R7/R9 good unlock
    wr(4'd1, 7'd3, w(0, 4'd1, 8'h5A));
    check(irq == 2'b11, "R10 irq both cores after unlock", 32'(irq), 32'd3);
    rd(4'd1, 7'd3, 32'd0, "R7 unlocked reads zero");
    rd(4'd1, A_STS0, 32'h08, "R9 sts0 set");
    rd(4'd2, A_STS1, 32'h08, "R9 sts1 set");

    // R11 clear
    wr(4'd1, A_CLR0, 32'h0);
    rd(4'd1, A_STS0, 32'h08, "R11 zero clear no effect");
    wr(4'd1, A_CLR0, 32'h08);
    rd(4'd1, A_STS0, 32'h00, "R11 clear bit");
    check(irq == 2'b10, "R10 irq0 low after clear", 32'(irq), 32'd2);

    // R9/R10 claim-locked semaphore unlocked by owner, enable mask
    wr(4'd2, 7'd4, w(0, 4'd2, 8'h00));
    check(irq == 2'b11, "R10 irq after sem4 unlock", 32'(irq), 32'd3);
    rd(4'd2, A_STS1, 32'h18, "R9 sts1 accumulates");
    wr(4'd2, 7'd69, 32'h18);
    check(irq == 2'b01, "R10 irq1 low after clear", 32'(irq), 32'd1);

    // R12 plain reads, unmapped
    rd(4'd1, 7'd7, 32'd0, "R12 plain read no lock 1");
    rd(4'd1, 7'd7, 32'd0, "R12 plain read no lock 2");
    wr(4'd1, 7'd96, w(1, 4'd1, 8'h33));
    wr(4'd1, 7'd67, 32'hFFFF_FFFF);
    rd(4'd1, 7'd96, 32'd0, "R12 unmapped read zero");
    rd(4'd1, 7'd0,  32'd0, "R12 unmapped write no lock");
    rd(4'd1, A_STS0, 32'h10, "R12 unmapped write kept status");

    repeat (3) @(negedge clk);
    check(exp_q.size() == 0, "R13 all reads answered", 32'(exp_q.size()), 32'd0);
    finish_run();
  end
endmodule